// File: doc/BRIEF.md
# Dual-Class Interrupt Pending Controller

The block gathers interrupt requests from 32 source units and presents them to a processor as two read-only pending views. One view is for normal interrupts (IRQ) and one is for fast interrupts (FIQ). Each source unit keeps a small bank of status bits. Hardware sets these bits with single-cycle pulses, and software clears them by writing ones. The controller latches no pending state of its own. A pending flag is the live OR of the bits in its source's bank, gated by a per-source enable and routed by a per-source class select.

Software reaches all state through a single-cycle register port with a combinational read path. Each source bank has its own word in the map, so a handler can read the bank, clear individual bits, and see the pending views follow at once. Two level outputs, registered once, signal to the processor that an IRQ or a FIQ is pending.

Top module: `intc_pending_top`

## Requirements
- R1: After reset, every status bit, the class-select word (offset 0x04) and the enable word (offset 0x08) read 0, and `irq_o` and `fiq_o` are 0.
- R2: Reading offset 0x00 returns, in bit n, the OR of source n's status bits, ANDed with enable bit n and with the inverse of class-select bit n.
- R3: Reading offset 0x10 returns, in bit n, the OR of source n's status bits, ANDed with enable bit n and with class-select bit n.
- R4: Source n's status bits read in the low bits at offset 0x80 + 4·n. A write there clears each status bit whose write-data bit is 1, and a 0 in the write data leaves the status bit unchanged.
- R5: Clearing some of a source's status bits leaves its pending flag at 1 while any other bit in that bank is still 1. The flag drops in the cycle after the last bit is cleared.
- R6: A set pulse on a status bit in the same cycle as a write-one-to-clear of that bit leaves the bit at 1.
- R7: Writes to offsets 0x00 and 0x10 change no state.
- R8: The enable word at offset 0x08 is read/write. A source whose enable bit is 0 shows 0 in both pending views.
- R9: The class-select word at offset 0x04 is read/write. Bit n = 1 routes source n to the FIQ view, and bit n = 0 routes it to the IRQ view.
- R10: `irq_o` equals the OR of the IRQ view one clock earlier, and `fiq_o` equals the OR of the FIQ view one clock earlier.
- R11: Reads from any unmapped or unaligned offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| src_set_i | input | 128 | Set pulses, 4 per source, source n at bits [4n+3:4n] |
| irq_o | output | 1 | Registered IRQ request level |
| fiq_o | output | 1 | Registered FIQ request level |

## Verification
A write or a set pulse takes effect at the clock edge that samples it. The bank contents, both pending views and the read data reflect it right after that edge, with no extra cycle. `irq_o` and `fiq_o` trail the pending views by exactly one more edge. The reference model follows this order on each edge. It first forms the registered outputs from the old state, then applies the clear and the set, with the set applied last. All outputs are compared 2 ns after every rising edge, while the inputs driven at the previous falling edge are still held.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned NUM_SRC  = 32;
  localparam int unsigned SRC_BITS = 4;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 32;

  localparam logic [ADDR_W-1:0] OFS_IRQ_PEND = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STEER    = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ENABLE   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_FIQ_PEND = 8'h10;
endpackage

// File: rtl/intc_src_bank.sv
module intc_src_bank #(
  parameter int unsigned SRC_BITS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SRC_BITS-1:0] set_i,
  input  logic [SRC_BITS-1:0] clr_i,
  output logic [SRC_BITS-1:0] stat_o,
  output logic                req_o
);
  logic [SRC_BITS-1:0] stat_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= set_i | (stat_q & ~clr_i);
  end

  assign stat_o = stat_q;
  assign req_o  = |stat_q;

  for (genvar b = 0; b < SRC_BITS; b++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[b] |=> stat_q[b]); // R6
    AST_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[b] && !clr_i[b]) |=> $stable(stat_q[b])); // R4
  end
endmodule

// File: rtl/intc_route.sv
module intc_route #(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] enable_i,
  input  logic [NUM_SRC-1:0] steer_i,
  output logic [NUM_SRC-1:0] irq_pend_o,
  output logic [NUM_SRC-1:0] fiq_pend_o
);
  logic [NUM_SRC-1:0] live;

  assign live       = req_i & enable_i;
  assign irq_pend_o = live & ~steer_i;
  assign fiq_pend_o = live &  steer_i;
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned N_SRC  = NUM_SRC,
  parameter int unsigned S_BITS = SRC_BITS,
  parameter int unsigned A_W    = ADDR_W,
  parameter int unsigned D_W    = DATA_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [A_W-1:0]            addr_i,
  input  logic [D_W-1:0]            wdata_i,
  output logic [D_W-1:0]            rdata_o,
  input  logic [N_SRC*S_BITS-1:0]   stat_i,
  input  logic [N_SRC-1:0]          irq_pend_i,
  input  logic [N_SRC-1:0]          fiq_pend_i,
  output logic [N_SRC-1:0]          steer_o,
  output logic [N_SRC-1:0]          enable_o,
  output logic [N_SRC*S_BITS-1:0]   clr_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic             bank_hit;
  logic [IDX_W-1:0] bank_idx;
  logic [N_SRC-1:0] steer_q, enable_q;

  // bank window: top address bit set, word aligned
  assign bank_hit = addr_i[A_W-1] && (addr_i[1:0] == 2'b00);
  assign bank_idx = addr_i[2 +: IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      steer_q  <= '0;
      enable_q <= '0;
    end else if (we_i) begin
      if (addr_i == OFS_STEER)  steer_q  <= wdata_i[N_SRC-1:0];
      if (addr_i == OFS_ENABLE) enable_q <= wdata_i[N_SRC-1:0];
    end
  end

  for (genvar n = 0; n < N_SRC; n++) begin : g_clr
    assign clr_o[n*S_BITS +: S_BITS] =
      (we_i && bank_hit && bank_idx == IDX_W'(n)) ? wdata_i[S_BITS-1:0] : '0;
  end

  always_comb begin
    rdata_o = '0;
    if (bank_hit)
      rdata_o[S_BITS-1:0] = stat_i[bank_idx*S_BITS +: S_BITS];
    else begin
      unique case (addr_i)
        OFS_IRQ_PEND: rdata_o[N_SRC-1:0] = irq_pend_i;
        OFS_FIQ_PEND: rdata_o[N_SRC-1:0] = fiq_pend_i;
        OFS_STEER:    rdata_o[N_SRC-1:0] = steer_q;
        OFS_ENABLE:   rdata_o[N_SRC-1:0] = enable_q;
        default:      rdata_o = '0;
      endcase
    end
  end

  assign steer_o  = steer_q;
  assign enable_o = enable_q;

  AST_RO_VIEWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == OFS_IRQ_PEND || addr_i == OFS_FIQ_PEND))
      |=> ($stable(steer_q) && $stable(enable_q))); // R7
  AST_STEER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_STEER) |=> steer_q == $past(wdata_i[N_SRC-1:0])); // R9
endmodule

// File: rtl/intc_pending_top.sv
module intc_pending_top
  import intc_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            rdata_o,
  input  logic [NUM_SRC*SRC_BITS-1:0]  src_set_i,
  output logic                         irq_o,
  output logic                         fiq_o
);
  logic [NUM_SRC*SRC_BITS-1:0] stat, clr;
  logic [NUM_SRC-1:0]          req, steer, enable, irq_pend, fiq_pend;
  logic                        irq_q, fiq_q;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    intc_src_bank #(.SRC_BITS(SRC_BITS)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (src_set_i[n*SRC_BITS +: SRC_BITS]),
      .clr_i  (clr[n*SRC_BITS +: SRC_BITS]),
      .stat_o (stat[n*SRC_BITS +: SRC_BITS]),
      .req_o  (req[n])
    );
  end

  intc_route #(.NUM_SRC(NUM_SRC)) u_route (
    .req_i      (req),
    .enable_i   (enable),
    .steer_i    (steer),
    .irq_pend_o (irq_pend),
    .fiq_pend_o (fiq_pend)
  );

  intc_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .stat_i     (stat),
    .irq_pend_i (irq_pend),
    .fiq_pend_i (fiq_pend),
    .steer_o    (steer),
    .enable_o   (enable),
    .clr_o      (clr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= |irq_pend;
      fiq_q <= |fiq_pend;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  AST_IRQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_pend) |=> irq_o); // R10
  AST_FIQ_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|fiq_pend) |=> !fiq_o); // R10
  AST_MASK_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_pend | fiq_pend) & ~enable) == '0); // R8
  AST_CLASS_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fiq_pend & ~steer) == '0); // R3
endmodule

// File: tb/intc_pending_top_tb.sv
module intc_pending_top_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         we_i = 1'b0;
  logic [7:0]   addr_i = '0;
  logic [31:0]  wdata_i = '0;
  logic [31:0]  rdata_o;
  logic [127:0] src_set_i = '0;
  logic         irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  intc_pending_top dut_i (.*);

  always #5 clk_i = ~clk_i;

  // reference model
  bit [3:0]  m_st [32];
  bit [31:0] m_steer, m_en;
  bit        m_irq, m_fiq;

  function automatic bit [31:0] m_view(bit fiq);
    bit [31:0] v = '0;
    for (int n = 0; n < 32; n++)
      v[n] = (m_st[n] != 0) && m_en[n] && (fiq ? m_steer[n] : !m_steer[n]);
    return v;
  endfunction

  function automatic bit [31:0] m_read(bit [7:0] a);
    if (a[7] && a[1:0] == 0) return {28'd0, m_st[a[6:2]]};
    case (a)
      8'h00: return m_view(0);
      8'h10: return m_view(1);
      8'h04: return m_steer;
      8'h08: return m_en;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag(bit [7:0] a);
    if (a[7] && a[1:0] == 0) return "R4";
    case (a)
      8'h00: return "R2";
      8'h10: return "R3";
      8'h04: return "R9";
      8'h08: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      foreach (m_st[n]) m_st[n] = '0;
      m_steer = '0; m_en = '0; m_irq = 0; m_fiq = 0;
    end else begin
      m_irq = |m_view(0);
      m_fiq = |m_view(1);
      if (we_i) begin
        if (addr_i == 8'h04) m_steer = wdata_i;
        if (addr_i == 8'h08) m_en = wdata_i;
        if (addr_i[7] && addr_i[1:0] == 0) m_st[addr_i[6:2]] &= ~wdata_i[3:0];
      end
      for (int n = 0; n < 32; n++) m_st[n] |= src_set_i[n*4 +: 4];
    end
    #2;
    if (!done) begin
      chk("R10 irq_o", {31'd0, irq_o}, {31'd0, m_irq});
      chk("R10 fiq_o", {31'd0, fiq_o}, {31'd0, m_fiq});
      chk(rd_tag(addr_i), rdata_o, m_read(addr_i));
    end
  end

  task automatic cyc(bit we, bit [7:0] a, bit [31:0] d, bit [127:0] s);
    @(negedge clk_i);
    we_i = we; addr_i = a; wdata_i = d; src_set_i = s;
  endtask

  task automatic idle(bit [7:0] a);
    cyc(0, a, 0, '0);
  endtask

  // directed read: drives address at negedge, compares after settling
  task automatic expect_rd(bit [7:0] a, bit [31:0] exp, string tag);
    @(negedge clk_i);
    we_i = 0; addr_i = a; wdata_i = 0; src_set_i = '0;
    #1 chk(tag, rdata_o, exp);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    expect_rd(8'h04, 0, "R1 steer");
    expect_rd(8'h08, 0, "R1 enable");
    expect_rd(8'h8C, 0, "R1 bank");
    chk("R1 irq_o", {31'd0, irq_o}, 0);

    cyc(1, 8'h08, 32'hFFFF_FFFF, '0);            // enable all
    cyc(0, 8'h00, 0, 128'h5 << 12);              // src3 bits 0,2
    expect_rd(8'h00, 32'h8, "R2 src3 pending");
    idle(8'h00);
    chk("R10 irq asserted", {31'd0, irq_o}, 1);

    cyc(1, 8'h8C, 32'h1, '0);                    // clear bit0 of src3
    expect_rd(8'h00, 32'h8, "R5 still pending");
    expect_rd(8'h8C, 32'h4, "R4 bit2 kept");
    cyc(1, 8'h8C, 32'h0, '0);                    // write zero
    expect_rd(8'h8C, 32'h4, "R4 zero write");
    cyc(1, 8'h8C, 32'h4, '0);
    expect_rd(8'h00, 32'h0, "R5 dropped");

    cyc(1, 8'h04, 32'h20, '0);                   // src5 -> FIQ
    cyc(0, 8'h10, 0, 128'h2 << 20);
    expect_rd(8'h10, 32'h20, "R3 fiq view");
    expect_rd(8'h00, 32'h0, "R9 not in irq view");
    cyc(1, 8'h94, 32'h2, 128'h2 << 20);          // collision
    expect_rd(8'h94, 32'h2, "R6 set wins");

    cyc(1, 8'h00, 32'hFFFF_FFFF, '0);
    cyc(1, 8'h10, 32'hFFFF_FFFF, '0);
    expect_rd(8'h04, 32'h20, "R7 steer unchanged");
    expect_rd(8'h08, 32'hFFFF_FFFF, "R7 enable unchanged");
    expect_rd(8'h94, 32'h2, "R7 bank unchanged");

    cyc(1, 8'h08, 32'hFFFF_FFDF, '0);            // disable src5
    expect_rd(8'h10, 32'h0, "R8 masked fiq");
    expect_rd(8'h00, 32'h0, "R8 masked irq");
    expect_rd(8'h20, 32'h0, "R11 unmapped");
    expect_rd(8'h82, 32'h0, "R11 unaligned");

    for (int i = 0; i < 3000; i++) begin
      bit [127:0] s = '0;
      bit [7:0] a;
      int k = $urandom_range(0, 9);
      for (int b = 0; b < 128; b++) s[b] = ($urandom_range(0, 40) == 0);
      case (k)
        0: a = 8'h00; 1: a = 8'h10; 2: a = 8'h04; 3: a = 8'h08;
        4: a = 8'h40;
        default: a = 8'h80 | (8'($urandom_range(0, 31)) << 2);
      endcase
      cyc($urandom_range(0, 2) == 0, a, $urandom, s);
    end
    idle(8'h00);
    idle(8'h00);
    @(negedge clk_i);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule